// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This combinational unit changes or reads one bit of a 64-bit operand. A bit index goes through a selector and a decoder and becomes a one-hot mask. Four operations share that mask. Set forces the chosen bit to 1. Clear forces it to 0. Invert flips it. Extract returns the chosen bit alone in bit 0 of the result.

The index comes from one of two sources. The first is the low six bits of the second register operand. The second is a 6-bit immediate field. A select input picks the source. Both forms give the same result for the same index.

The unit holds no state. The result settles in the same cycle from the operands, the immediate, the select input and the operation code. Instruction decode and writeback belong to the surrounding pipeline.

Top module: `sbit_unit`

Data path, in order:
- Index selector: picks the index source.
- Mask decoder: turns the index into a one-hot mask.
- Per-bit lanes: apply the operation to each bit. They use one case on the operation code.
- Extract reducer: reduces operand AND mask to one bit.

There is no clocked state, so the unit has no states and no transitions.

## Requirements
- R1: When `idx_imm_i` is 1, the bit index is `imm_i[5:0]`. When it is 0, the index is `rs2_i[5:0]`, and bits 63:6 of `rs2_i` are ignored, so an index of 64 or more wraps modulo 64.
- R2: With `op_i` = 2'b00 (set), the result is `rs1_i` OR (1 << index).
- R3: With `op_i` = 2'b01 (clear), the result is `rs1_i` AND NOT (1 << index).
- R4: With `op_i` = 2'b10 (invert), the result is `rs1_i` XOR (1 << index).
- R5: With `op_i` = 2'b11 (extract), bit 0 of the result equals bit [index] of `rs1_i`, and bits 63:1 are zero.
- R6: The register-index form and the immediate-index form give identical results for the same index value.
- R7: For set, clear and invert, every result bit other than bit [index] equals the same bit of `rs1_i`.
- R8: The unused index source has no effect. `imm_i` is ignored when `idx_imm_i` = 0, and `rs2_i` is ignored when `idx_imm_i` = 1.
- R9: Indices 0 and 63 reach bit 0 and bit 63 of the 64-bit result. There is no 32-bit variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs1_i | input | 64 | Operand whose bit is modified or read |
| rs2_i | input | 64 | Register index source; only bits 5:0 are used |
| imm_i | input | 6 | Immediate index |
| idx_imm_i | input | 1 | 1 selects `imm_i` as the index, 0 selects `rs2_i[5:0]` |
| op_i | input | 2 | 00 set, 01 clear, 10 invert, 11 extract |
| result_o | output | 64 | Operation result |

## Verification
Random operands are tried with all four operation codes and both index sources.

Directed vectors cover these cases:
- **Indices 0 and 63.** These separate a correct decoder from an off-by-one or truncated one.
- **Register indices of 64 and above.** These show that only the low six bits are used.
- **Operands of all ones and all zeros.** These show whether set and clear are stuck or inverted.
- **Matching register and immediate indices.** These confirm that both forms agree.
- **Junk in the unused index source.** This shows that the selector ignores that source.

// File: rtl/sbit_pkg.sv
package sbit_pkg;

    localparam int unsigned SBIT_XLEN = 64;
    localparam int unsigned SBIT_IDXW = $clog2(SBIT_XLEN);

    typedef enum logic [1:0] {
        SBIT_OP_SET = 2'b00,
        SBIT_OP_CLR = 2'b01,
        SBIT_OP_INV = 2'b10,
        SBIT_OP_EXT = 2'b11
    } sbit_op_e;

endpackage

// File: rtl/sbit_index_sel.sv
module sbit_index_sel #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned IDXW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] reg_src_i,
    input  logic [IDXW-1:0] imm_src_i,
    input  logic            use_imm_i,
    output logic [IDXW-1:0] idx_o
);

    // Only the low IDXW bits of the register source matter: wrap modulo XLEN.
    logic [IDXW-1:0] reg_idx;
    assign reg_idx = reg_src_i[IDXW-1:0];

    always_comb begin
        if (use_imm_i) idx_o = imm_src_i;
        else           idx_o = reg_idx;
    end

endmodule

// File: rtl/sbit_mask_dec.sv
module sbit_mask_dec #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned IDXW = $clog2(XLEN)
) (
    input  logic [IDXW-1:0] idx_i,
    output logic [XLEN-1:0] onehot_o
);

    for (genvar g = 0; g < XLEN; g++) begin : g_dec
        assign onehot_o[g] = (idx_i == IDXW'(g));
    end

endmodule

// File: rtl/sbit_extract.sv
module sbit_extract #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] word_i,
    input  logic [XLEN-1:0] onehot_i,
    output logic            bit_o
);

    // AND-OR reduction against the shared mask replaces a right shifter.
    assign bit_o = |(word_i & onehot_i);

endmodule

// File: rtl/sbit_unit.sv
module sbit_unit
    import sbit_pkg::*;
#(
    parameter int unsigned XLEN = SBIT_XLEN,
    parameter int unsigned IDXW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] rs1_i,
    input  logic [XLEN-1:0] rs2_i,
    input  logic [IDXW-1:0] imm_i,
    input  logic            idx_imm_i,
    input  logic [1:0]      op_i,
    output logic [XLEN-1:0] result_o
);

    logic [IDXW-1:0] idx_w;
    logic [XLEN-1:0] mask_w;
    logic            ext_bit_w;
    sbit_op_e        op_w;

    assign op_w = sbit_op_e'(op_i);

    sbit_index_sel #(.XLEN(XLEN), .IDXW(IDXW)) u_sel (
        .reg_src_i (rs2_i),
        .imm_src_i (imm_i),
        .use_imm_i (idx_imm_i),
        .idx_o     (idx_w)
    );

    sbit_mask_dec #(.XLEN(XLEN), .IDXW(IDXW)) u_dec (
        .idx_i    (idx_w),
        .onehot_o (mask_w)
    );

    sbit_extract #(.XLEN(XLEN)) u_ext (
        .word_i   (rs1_i),
        .onehot_i (mask_w),
        .bit_o    (ext_bit_w)
    );

    for (genvar g = 0; g < XLEN; g++) begin : g_lane
        always_comb begin
            unique case (op_w)
                SBIT_OP_SET: result_o[g] = rs1_i[g] | mask_w[g];
                SBIT_OP_CLR: result_o[g] = rs1_i[g] & ~mask_w[g];
                SBIT_OP_INV: result_o[g] = rs1_i[g] ^ mask_w[g];
                SBIT_OP_EXT: result_o[g] = (g == 0) ? ext_bit_w : 1'b0;
                default:     result_o[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/sbit_unit_chk.sv
module sbit_unit_chk #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned IDXW = $clog2(XLEN)
) (
    input logic [XLEN-1:0] rs1_i,
    input logic [XLEN-1:0] rs2_i,
    input logic [IDXW-1:0] imm_i,
    input logic            idx_imm_i,
    input logic [1:0]      op_i,
    input logic [XLEN-1:0] mask_w,
    input logic [XLEN-1:0] result_o
);

    logic [IDXW-1:0] want_idx;
    assign want_idx = idx_imm_i ? imm_i : rs2_i[IDXW-1:0];

    always_comb begin
        // R1
        mask_onehot_chk: assert ($onehot(mask_w) && mask_w[want_idx]);
        // R2
        set_bit_chk: assert (op_i != 2'b00 || result_o[want_idx] == 1'b1);
        // R3
        clr_bit_chk: assert (op_i != 2'b01 || result_o[want_idx] == 1'b0);
        // R4
        inv_bit_chk: assert (op_i != 2'b10 || result_o[want_idx] == ~rs1_i[want_idx]);
        // R5
        ext_bit_chk: assert (op_i != 2'b11 ||
                             (result_o[0] == rs1_i[want_idx] && result_o[XLEN-1:1] == '0));
        // R7
        others_kept_chk: assert (op_i == 2'b11 || (result_o & ~mask_w) == (rs1_i & ~mask_w));
    end

endmodule

bind sbit_unit sbit_unit_chk #(.XLEN(XLEN), .IDXW(IDXW)) u_sbit_chk (
    .rs1_i     (rs1_i),
    .rs2_i     (rs2_i),
    .imm_i     (imm_i),
    .idx_imm_i (idx_imm_i),
    .op_i      (op_i),
    .mask_w    (mask_w),
    .result_o  (result_o)
);

// File: tb/test_sbit_unit.sv
module test_sbit_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] rs1, rs2, res;
    logic [5:0]  imm;
    logic        use_imm;
    logic [1:0]  op;
    int unsigned vectors = 0;
    int unsigned fails = 0;

    always #10 clk = ~clk;

    sbit_unit i_sbit_unit (
        .rs1_i     (rs1),
        .rs2_i     (rs2),
        .imm_i     (imm),
        .idx_imm_i (use_imm),
        .op_i      (op),
        .result_o  (res)
    );

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [5:0] im, input logic ui,
                                          input logic [1:0] o);
        logic [5:0]  ix;
        logic [63:0] m;
        ix = ui ? im : b[5:0];
        m  = 64'd1 << ix;
        case (o)
            2'b00:   return a | m;
            2'b01:   return a & ~m;
            2'b10:   return a ^ m;
            default: return {63'd0, a[ix]};
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] exp);
        vectors++;
        if (res !== exp) begin
            fails++;
            $display("FAIL %s: op=%b idx_imm=%b got %h expected %h", tag, op, use_imm, res, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [63:0] a, input logic [63:0] b,
                         input logic [5:0] im, input logic ui, input logic [1:0] o);
        @(posedge clk);
        rs1 = a; rs2 = b; imm = im; use_imm = ui; op = o;
        @(negedge clk);
        check(tag, model(a, b, im, ui, o));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [63:0] ra, rb, r_reg;
        logic [5:0]  ri;
        logic [1:0]  ro;
        void'($urandom(32'd1234));
        rs1 = '0; rs2 = '0; imm = '0; use_imm = 1'b0; op = 2'b00;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle zero operands", 64'd1);

        // R9 boundaries, R2..R5 on all ones / all zeros
        for (int o = 0; o < 4; o++) begin
            apply("R9 idx0 ones",   '1, 64'd0,  6'd0,  1'b0, 2'(o));
            apply("R9 idx63 ones",  '1, 64'd63, 6'd0,  1'b0, 2'(o));
            apply("R9 idx63 zeros", '0, 64'd0,  6'd63, 1'b1, 2'(o));
            apply("R9 idx0 zeros",  '0, 64'd0,  6'd0,  1'b1, 2'(o));
        end
        apply("R3 clear top", 64'h8000_0000_0000_0001, 64'd63, 6'd0, 1'b0, 2'b01);
        check("R3 clear top exact", 64'h0000_0000_0000_0001);
        apply("R5 extract top", 64'h8000_0000_0000_0000, 64'd0, 6'd63, 1'b1, 2'b11);
        check("R5 extract top exact", 64'd1);

        // R1 wrap: 64 -> 0, 127 -> 63, junk high bits
        apply("R1 wrap 64", 64'h0, 64'd64, 6'd5, 1'b0, 2'b00);
        check("R1 wrap 64 exact", 64'd1);
        apply("R1 wrap 127", 64'h0, 64'd127, 6'd5, 1'b0, 2'b10);
        check("R1 wrap 127 exact", 64'h8000_0000_0000_0000);
        apply("R1 junk high", 64'h0, 64'hDEAD_BEEF_0000_0FC3, 6'd0, 1'b0, 2'b00);
        check("R1 junk high exact", 64'd8);

        // R8 unused source ignored
        apply("R8 imm ignored", 64'h0, 64'd4, 6'd40, 1'b0, 2'b00);
        check("R8 imm ignored exact", 64'd16);
        apply("R8 rs2 ignored", 64'h0, 64'd40, 6'd4, 1'b1, 2'b00);
        check("R8 rs2 ignored exact", 64'd16);

        // R6 reg form vs imm form, R7 untouched bits via model
        for (int n = 0; n < 400; n++) begin
            ra = {$urandom, $urandom};
            ri = 6'($urandom);
            ro = 2'($urandom);
            apply("R6 reg form", ra, {$urandom, 26'($urandom), ri}, 6'($urandom), 1'b0, ro);
            r_reg = res;
            apply("R6 imm form", ra, {$urandom, $urandom}, ri, 1'b1, ro);
            vectors++;
            if (res !== r_reg) begin
                fails++;
                $display("FAIL R6 forms differ: got %h expected %h", res, r_reg);
            end
        end

        // R2 R3 R4 R5 R7 random sweep
        for (int n = 0; n < 3000; n++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            ro = 2'($urandom);
            case (ro)
                2'b00:   apply("R2/R7 set random",    ra, rb, 6'($urandom), 1'($urandom), ro);
                2'b01:   apply("R3/R7 clear random",  ra, rb, 6'($urandom), 1'($urandom), ro);
                2'b10:   apply("R4/R7 invert random", ra, rb, 6'($urandom), 1'($urandom), ro);
                default: apply("R5 extract random",   ra, rb, 6'($urandom), 1'($urandom), ro);
            endcase
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule